// File: doc/BRIEF.md
# Reset Button Hold-Time Classifier

This block watches a mechanical reset button and decides which of two recovery actions the system should take. The raw button level is synchronised, and a press onset starts a short confirmation window. If the button is still down when the window closes, the press is accepted. The block then raises a busy flag and starts a long decision window. When that window expires, the block checks the button once. A released button produces a plain reboot request. A button that is still held produces a restore-defaults request.

Both requests are single-cycle pulses, and the rest of the chip acts on them. All timing is counted in ticks of a slow time base supplied from outside. The two window lengths are parameters in ticks, so a system can set them to roughly 100 ms and 3 s, and a test can make them short. The decision always falls a fixed number of ticks after confirmation, however early the button is released.

Top module: `rst_hold_classifier`

## Requirements
- R1: While `rst_n` is low and after it rises, `busy`, `reboot_req` and `restore_req` are 0, and the block is armed for a new press.
- R2: The button counts as pressed when the synchronised `btn_raw` equals `PRESS_LEVEL` (default 1). A released-to-pressed transition while armed opens a confirmation window of `CONFIRM_TICKS` ticks. Any further transitions during that window have no effect, so a bouncing press yields exactly one outcome.
- R3: If the button is released when the confirmation window closes, the press is discarded. No request is issued, `busy` never rises, and the block re-arms so that the next press is handled normally.
- R4: If the button is pressed when the confirmation window closes, `busy` rises and stays high until the action request.
- R5: The action request appears in the cycle after the `DECIDE_TICKS`-th tick seen while `busy` is high. Releasing the button earlier does not change this moment.
- R6: A released button at the decision point yields a one-cycle `reboot_req` pulse.
- R7: A held button at the decision point yields a one-cycle `restore_req` pulse.
- R8: `reboot_req` and `restore_req` are never high together, and `busy` is low in the cycle that carries either pulse.
- R9: After a request, while the button stays held, no new sequence starts and `busy` stays low. After release, the block is armed again.
- R10: The `tick` input is a one-cycle enable. Only cycles with `tick` high advance either window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the slow time base |
| btn_raw | input | 1 | Asynchronous button level |
| busy | output | 1 | High from press confirmation until the request |
| reboot_req | output | 1 | One-cycle plain reboot request |
| restore_req | output | 1 | One-cycle restore-defaults request |

## Verification
The bench applies four kinds of press:
- A press shorter than the confirmation window, which must vanish without raising `busy`.
- A press released after confirmation but before the decision, which must give a reboot.
- A press held past the decision and beyond, which must give a restore and then stay quiet until release.
- A bouncing onset that settles pressed, which must give exactly one restore.

For each request, the bench counts the ticks seen while `busy` was high and compares the count with the decision length. This separates a correct decision point from one that is off by a tick, and from one triggered by the release itself.

// File: rtl/rst_hold_classifier.sv
module rst_hold_classifier #(
  parameter int CONFIRM_TICKS = 10,
  parameter int DECIDE_TICKS  = 300,
  parameter bit PRESS_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_raw,
  output logic busy,
  output logic reboot_req,
  output logic restore_req
);
  localparam int MAX_TICKS = (CONFIRM_TICKS > DECIDE_TICKS) ? CONFIRM_TICKS : DECIDE_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] CONF_LAST = CW'(CONFIRM_TICKS - 1);
  localparam logic [CW-1:0] DEC_LAST  = CW'(DECIDE_TICKS - 1);

  typedef enum logic [1:0] {ARMED, CONFIRM, HOLD, DRAIN} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          sync1, sync2, pressed_q;
  logic          pressed;

  assign pressed = (sync2 == PRESS_LEVEL);
  assign busy    = (st == HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= ~PRESS_LEVEL;
      sync2     <= ~PRESS_LEVEL;
      pressed_q <= 1'b0;
    end else begin
      sync1     <= btn_raw;
      sync2     <= sync1;
      pressed_q <= pressed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ARMED;
      cnt         <= '0;
      reboot_req  <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      reboot_req  <= 1'b0;
      restore_req <= 1'b0;
      case (st)
        ARMED: begin
          cnt <= '0;
          if (pressed && !pressed_q) st <= CONFIRM;
        end
        CONFIRM: if (tick) begin
          if (cnt == CONF_LAST) begin
            cnt <= '0;
            st  <= pressed ? HOLD : ARMED;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HOLD: if (tick) begin
          if (cnt == DEC_LAST) begin
            cnt         <= '0;
            restore_req <= pressed;
            reboot_req  <= !pressed;
            st          <= DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: if (!pressed) st <= ARMED;
      endcase
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reboot_req && restore_req)); // R8
  AST_REQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reboot_req || restore_req) |-> ($past(busy) && !busy)); // R8
  AST_REBOOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req); // R6
  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |=> !restore_req); // R7
  AST_RESTORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> $past(pressed)); // R7
  AST_REBOOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> !$past(pressed)); // R6
  AST_DRAIN_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DRAIN && pressed) |=> !busy); // R9
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy); // R10
endmodule

// File: tb/rst_hold_classifier_test.sv
module rst_hold_classifier_test;
  localparam int CONF = 4;
  localparam int DEC  = 12;
  localparam int DIV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic btn = 1'b0;
  logic busy, reboot_req, restore_req;

  int checks = 0;
  int failures = 0;
  bit busy_seen = 1'b0;
  int hold_ticks = 0;
  string exp_q[$];

  always #4 clk = ~clk;

  rst_hold_classifier #(.CONFIRM_TICKS(CONF), .DECIDE_TICKS(DEC), .PRESS_LEVEL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_raw(btn),
    .busy(busy), .reboot_req(reboot_req), .restore_req(restore_req));

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic press(input int len, input string expect_kind);
    if (expect_kind != "") exp_q.push_back(expect_kind);
    btn = 1'b1;
    cycles(len);
    btn = 1'b0;
  endtask

  // R10: time base is a one-cycle enable every DIV clocks
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #1;
      div  = (div == DIV - 1) ? 0 : div + 1;
      tick = (div == DIV - 1);
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) busy_seen = 1'b1;
        if (reboot_req || restore_req) begin
          string got;
          got = restore_req ? "restore" : "reboot";
          check(!(reboot_req && restore_req) && !busy, "R8",
                $sformatf("both=%0b busy=%0b", reboot_req && restore_req, busy), "both=0 busy=0");
          if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected request", got, "none");
          end else begin
            string want;
            want = exp_q.pop_front();
            check(got == want, "R6/R7 kind", got, want);
            check(hold_ticks == DEC, "R5 decision ticks",
                  $sformatf("%0d", hold_ticks), $sformatf("%0d", DEC));
          end
          hold_ticks = 0;
        end
        if (busy && tick) hold_ticks++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles(6);
    check(!busy && !reboot_req && !restore_req, "R1 during reset",
          $sformatf("%0b%0b%0b", busy, reboot_req, restore_req), "000");
    rst_n = 1'b1;
    cycles(3);
    check(!busy && !reboot_req && !restore_req, "R1 after reset",
          $sformatf("%0b%0b%0b", busy, reboot_req, restore_req), "000");

    // R3: short glitch is discarded
    busy_seen = 1'b0;
    press(12, "");
    cycles(80);
    check(!busy_seen, "R3 glitch raised busy", $sformatf("%0b", busy_seen), "0");

    // R3 re-arm + R4 + R6: released before decision -> reboot
    busy_seen = 1'b0;
    press(60, "reboot");
    check(busy, "R4 busy while pending", $sformatf("%0b", busy), "1");
    cycles(140);
    check(busy_seen && !busy, "R4 busy span", $sformatf("%0b/%0b", busy_seen, busy), "1/0");

    // R7 + R9: held past decision, then held longer
    exp_q.push_back("restore");
    btn = 1'b1;
    cycles(200);
    check(!busy, "R9 busy while held after request", $sformatf("%0b", busy), "0");
    cycles(150);
    btn = 1'b0;
    cycles(40);

    // R2: bouncing onset, one restore
    for (int i = 0; i < 4; i++) begin
      btn = 1'b1; cycles(2);
      btn = 1'b0; cycles(2);
    end
    press(220, "restore");
    cycles(60);

    // R9: re-armed after release -> reboot works again
    press(50, "reboot");
    cycles(150);

    check(exp_q.size() == 0, "R5 all requests issued", $sformatf("%0d pending", exp_q.size()), "0 pending");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule